// File: doc/BRIEF.md
# Bus-Mapped Four-Lane Event Counter

This peripheral holds four free-running counters of unequal widths (32, 16, 8 and 4 bits) behind a classic single-transfer Wishbone slave port. Each lane advances by one per clock only while two gates agree: a pin-level hardware enable supplied by neighbouring logic, and a software enable bit that a bus master sets through the register map. This lets firmware arm a channel while the surrounding hardware decides exactly when it is allowed to count.

A bus master reads every lane as its own 32-bit word, reads and rewrites the software gate word, and samples the live hardware enable pins. Every transfer is answered with a registered acknowledge one clock after the strobe is seen. Read data is also registered, and it is loaded only by reads. The acknowledge comes from a two-state responder machine. `RSP_IDLE` moves to `RSP_ACK` when a transfer is seen. `RSP_ACK` stays in `RSP_ACK` when another transfer is seen, and returns to `RSP_IDLE` otherwise. The acknowledge output is high exactly in `RSP_ACK`.

Top module: `wb_multi_counter`

## Requirements
- R1: Lane 0 is 32 bits, lane 1 is 16 bits, lane 2 is 8 bits and lane 3 is 4 bits wide. A lane adds one on each clock edge at which its effective enable is high, and it wraps modulo two to the power of its width.
- R2: The effective enable of lane i is `hw_en_i[i]` AND software gate bit i. With either of the two low, the lane holds its value.
- R3: A transfer exists only when `wb_cyc_i` and `wb_stb_i` are both high. It is a write when `wb_we_i` is 1 and a read when `wb_we_i` is 0. A strobe without a cycle has no effect.
- R4: `wb_ack_o` is high in the clock after a cycle that carried a transfer, and low in the clock after a cycle that did not.
- R5: `wb_dat_o` is a register that is loaded only by a read transfer. It keeps its value through idle cycles and write transfers.
- R6: The read map uses base 0x11A00000. Lane i is at base+0x100+4*i, zero-extended to 32 bits. The software gate word is at base+0x200 in bits [3:0]. The hardware enable pins read back at base+0x300 in bits [3:0]. Upper bits of these words read as zero.
- R7: A read at any address that is not one of the six mapped words returns zero. This includes misaligned addresses and offsets without the base.
- R8: Only the software gate word is writable, and it is loaded from `wb_dat_i[3:0]`. Writes to lane or pin-readback addresses, or to unmapped addresses, change nothing. `wb_sel_i` is ignored.
- R9: A synchronous active-high `rst` clears all lanes, the software gate word (so every lane is stopped), the acknowledge and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte selects (ignored) |
| hw_en_i | input | 4 | Per-lane hardware enable |
| wb_dat_o | output | 32 | Registered read data |
| wb_ack_o | output | 1 | Registered acknowledge |

## Verification
If the responder machine is stuck, `wb_ack_o` goes wrong on the first transfer, one clock after the strobe. A corrupted software gate word shows up either on the next read of base+0x200, or as a lane count that differs from the number of enabled edges. A lane that counts too far, wraps at the wrong width or ignores one of its gates shows a wrong value on the first read after a window of precisely known length. Decode faults show on the first read of the affected or unmapped address, one clock after the strobe.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;

    localparam int NCH      = 4;
    localparam int OFF_LANE = 'h100;
    localparam int OFF_GATE = 'h200;
    localparam int OFF_PINS = 'h300;

    // Width of each counter lane, by index.
    function automatic int lane_width(input int idx);
        case (idx)
            0:       return 32;
            1:       return 16;
            2:       return 8;
            default: return 4;
        endcase
    endfunction

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_ACK  = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/ctr_lane.sv
module ctr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wb_resp_fsm.sv
module wb_resp_fsm
    import mcnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    input  logic we,
    output logic rd_req,
    output logic wr_req,
    output logic ack
);

    rsp_state_e state_q, state_d;
    logic       xfer;

    assign xfer = cyc & stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = xfer ? RSP_ACK : RSP_IDLE;
            RSP_ACK:  state_d = xfer ? RSP_ACK : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_comb begin
        ack    = (state_q == RSP_ACK);
        rd_req = xfer & ~we;
        wr_req = xfer & we;
    end

endmodule

// File: rtl/mcnt_regmap.sv
module mcnt_regmap
    import mcnt_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter int              LANES  = 4,
    parameter logic [ADDR_W-1:0] BASE = 32'h11A0_0000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_req,
    input  logic                          wr_req,
    input  logic [ADDR_W-1:0]             adr,
    input  logic [LANES-1:0]              wdat,
    input  logic [LANES-1:0][DATA_W-1:0]  lane_words,
    input  logic [LANES-1:0]              pins,
    output logic [LANES-1:0]              gate,
    output logic [DATA_W-1:0]             rdata
);

    localparam logic [ADDR_W-1:0] A_GATE = BASE + ADDR_W'(OFF_GATE);
    localparam logic [ADDR_W-1:0] A_PINS = BASE + ADDR_W'(OFF_PINS);
    localparam int                STRIDE = DATA_W / 8;

    logic [DATA_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        if (adr == A_GATE) begin
            sel_word = DATA_W'(gate);
        end else if (adr == A_PINS) begin
            sel_word = DATA_W'(pins);
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (adr == BASE + ADDR_W'(OFF_LANE + STRIDE * i)) begin
                    sel_word = lane_words[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= '0;
        end else if (wr_req && adr == A_GATE) begin
            gate <= wdat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= sel_word;
        end
    end

endmodule

// File: rtl/wb_multi_counter.sv
module wb_multi_counter
    import mcnt_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'h11A0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic [DATA_W/8-1:0] wb_sel_i,
    input  logic [NCH-1:0]    hw_en_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o
);

    logic                          rd_req, wr_req;
    logic [NCH-1:0]                gate;
    logic [NCH-1:0]                lane_go;
    logic [NCH-1:0][DATA_W-1:0]    lane_words;
    logic                          unused_bits;

    assign unused_bits = ^{wb_sel_i, wb_dat_i[DATA_W-1:NCH]};
    assign lane_go     = hw_en_i & gate;

    wb_resp_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cyc    (wb_cyc_i),
        .stb    (wb_stb_i),
        .we     (wb_we_i),
        .rd_req (rd_req),
        .wr_req (wr_req),
        .ack    (wb_ack_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        localparam int LW = lane_width(g);
        logic [LW-1:0] cnt;

        ctr_lane #(.W(LW)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .en    (lane_go[g]),
            .count (cnt)
        );

        assign lane_words[g] = DATA_W'(cnt);
    end

    mcnt_regmap #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (NCH),
        .BASE   (BASE)
    ) u_map (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .adr        (wb_adr_i),
        .wdat       (wb_dat_i[NCH-1:0]),
        .lane_words (lane_words),
        .pins       (hw_en_i),
        .gate       (gate),
        .rdata      (wb_dat_o)
    );

endmodule

// File: rtl/mcnt_chk.sv
module mcnt_chk #(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter int              LANES  = 4,
    parameter logic [ADDR_W-1:0] BASE = 32'h11A0_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              wb_cyc_i,
    input logic              wb_stb_i,
    input logic              wb_we_i,
    input logic [ADDR_W-1:0] wb_adr_i,
    input logic [LANES-1:0]  hw_en_i,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic              wb_ack_o
);

    logic xfer, rd, mapped;

    assign xfer = wb_cyc_i && wb_stb_i;
    assign rd   = xfer && !wb_we_i;

    always_comb begin
        mapped = (wb_adr_i == BASE + 32'h200) || (wb_adr_i == BASE + 32'h300);
        for (int i = 0; i < LANES; i++) begin
            if (wb_adr_i == BASE + ADDR_W'(32'h100 + 4 * i)) mapped = 1'b1;
        end
    end

    // R4
    ack_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> wb_ack_o);

    // R4
    ack_drop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> !wb_ack_o);

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(wb_dat_o));

    // R6
    pin_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && wb_adr_i == BASE + 32'h300) |=> (wb_dat_o == DATA_W'($past(hw_en_i))));

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !mapped) |=> (wb_dat_o == '0));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!wb_ack_o && wb_dat_o == '0));

endmodule

bind wb_multi_counter mcnt_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (NCH),
    .BASE   (BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wb_cyc_i (wb_cyc_i),
    .wb_stb_i (wb_stb_i),
    .wb_we_i  (wb_we_i),
    .wb_adr_i (wb_adr_i),
    .hw_en_i  (hw_en_i),
    .wb_dat_o (wb_dat_o),
    .wb_ack_o (wb_ack_o)
);

// File: tb/wb_multi_counter_tb.sv
module wb_multi_counter_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] B      = 32'h11A0_0000;
    localparam logic [31:0] A_GATE = B + 32'h200;
    localparam logic [31:0] A_PINS = B + 32'h300;
    localparam int          WATCHDOG = 20000;

    typedef struct packed {
        logic        we;
        logic [3:0]  sel;
        logic [3:0]  pins;
        logic [31:0] adr;
        logic [31:0] wdat;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'hF, 4'h0, A_GATE,         32'h0,        32'h0},  // R9 gate cleared
        '{1'b1, 4'hF, 4'h0, A_GATE,         32'h5,        32'h0},
        '{1'b0, 4'hF, 4'h0, A_GATE,         32'h0,        32'h5},  // R8
        '{1'b1, 4'h0, 4'h0, A_GATE,         32'hFFFF_FFF3,32'h0},  // R8 sel ignored
        '{1'b0, 4'hF, 4'h0, A_GATE,         32'h0,        32'h3},  // R8
        '{1'b1, 4'hF, 4'h0, A_PINS,         32'hF,        32'h0},
        '{1'b0, 4'hF, 4'h0, A_GATE,         32'h0,        32'h3},  // R8 read-only
        '{1'b0, 4'hF, 4'hA, A_PINS,         32'h0,        32'hA},  // R6
        '{1'b0, 4'hF, 4'h0, B + 32'h400,    32'h0,        32'h0},  // R7
        '{1'b0, 4'hF, 4'h0, B + 32'h102,    32'h0,        32'h0},  // R7
        '{1'b0, 4'hF, 4'h0, 32'h0000_0100,  32'h0,        32'h0},  // R7
        '{1'b0, 4'hF, 4'h5, A_PINS,         32'h0,        32'h5}   // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] adr = '0, wdat = '0;
    logic [3:0]  sel = '0, pins = '0;
    logic [31:0] dat_o;
    logic        ack_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_multi_counter u_dut (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc_i (cyc),
        .wb_stb_i (stb),
        .wb_we_i  (we),
        .wb_adr_i (adr),
        .wb_dat_i (wdat),
        .wb_sel_i (sel),
        .hw_en_i  (pins),
        .wb_dat_o (dat_o),
        .wb_ack_o (ack_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One single-clock transfer; returns the registered read data.
    task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = s;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        check("R4 ack after transfer", {31'b0, ack_o}, 32'h1);
        rd = dat_o;
        @(negedge clk);
        check("R4 ack drops when idle", {31'b0, ack_o}, 32'h0);
    endtask

    task automatic run_window(input logic [3:0] p, input int n);
        @(negedge clk);
        pins = p;
        repeat (n) @(negedge clk);
        pins = 4'h0;
    endtask

    task automatic read_lanes(input logic [31:0] e0, input logic [31:0] e1,
                              input logic [31:0] e2, input logic [31:0] e3, input string req);
        logic [31:0] r;
        xfer(1'b0, B + 32'h100, 0, 4'hF, r); check(req, r, e0);
        xfer(1'b0, B + 32'h104, 0, 4'hF, r); check(req, r, e1);
        xfer(1'b0, B + 32'h108, 0, 4'hF, r); check(req, r, e2);
        xfer(1'b0, B + 32'h10C, 0, 4'hF, r); check(req, r, e3);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 ack after reset", {31'b0, ack_o}, 32'h0);
        check("R9 rdata after reset", dat_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            pins = VECS[i].pins;
            xfer(VECS[i].we, VECS[i].adr, VECS[i].wdat, VECS[i].sel, r);
            if (!VECS[i].we) check("R6/R7/R8 table read", r, VECS[i].exp);
        end
        pins = 4'h0;

        // R9 mid-run reset clears gate and lanes
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 rdata cleared", dat_o, 32'h0);
        xfer(1'b0, A_GATE, 0, 4'hF, r);
        check("R9 gate cleared", r, 32'h0);

        // R2 gate low: pins alone do not count
        run_window(4'hF, 5);
        read_lanes(0, 0, 0, 0, "R2 gate low holds");

        // R1 counting with both enables
        xfer(1'b1, A_GATE, 32'hF, 4'hF, r);
        run_window(4'hF, 20);
        read_lanes(20, 20, 20, 4, "R1 count 20");
        run_window(4'hF, 300);
        read_lanes(320, 320, 64, 0, "R1 wrap at width");

        // R2 per-lane AND: gate 0011, pins 0110 -> only lane 1
        xfer(1'b1, A_GATE, 32'h3, 4'hF, r);
        run_window(4'h6, 10);
        read_lanes(320, 330, 64, 0, "R2 AND of enables");

        // R8 lane words are read-only
        xfer(1'b1, B + 32'h104, 32'h0, 4'hF, r);
        xfer(1'b0, B + 32'h104, 0, 4'hF, r);
        check("R8 lane write ignored", r, 32'd330);

        // R5 read data holds through idle and writes
        held = dat_o;
        repeat (3) @(negedge clk);
        check("R5 hold idle", dat_o, held);
        xfer(1'b1, A_GATE, 32'h3, 4'hF, r);
        check("R5 hold across write", r, held);

        // R3 strobe without cycle: no ack, no write
        @(negedge clk);
        cyc = 1'b0; stb = 1'b1; we = 1'b1; adr = A_GATE; wdat = 32'h0;
        @(negedge clk);
        stb = 1'b0; we = 1'b0;
        check("R3 no ack without cyc", {31'b0, ack_o}, 32'h0);
        xfer(1'b0, A_GATE, 0, 4'hF, r);
        check("R3 no write without cyc", r, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule